// File: doc/BRIEF.md
# Two-Way FIFO Cache Tag Directory

This block keeps the tag store and the hit/miss decision of a small set-associative cache. It works on an 8-bit byte address space, with 4-byte lines, 4 sets and 2 ways per set. Each cycle it can take one lookup. The lookup compares the request tag against both slots of the indexed set. On a miss, it writes the tag into a victim slot at once, so the line counts as allocated.

Victims are chosen first-in-first-out. Each set has a one-bit fill pointer that moves only when a line is allocated. Hits therefore never change the eviction order. The outcome (hit, miss and the way involved) is registered and appears one cycle after the request. The tag and valid bit of every slot are brought out so that the directory can be observed directly. The data array, the backing memory, write policy and coherence are handled elsewhere.

Top module: `cache_tag_dir`

## Requirements
- R1: A synchronous active-high `rst` clears every valid bit, drives `hit` and `miss` low and returns every set's fill pointer to way 0.
- R2: A request address is split into a byte offset in bits [1:0], a set index in bits [3:2] and a 4-bit tag in bits [7:4]. Two addresses that differ only in the offset refer to the same line.
- R3: A request hits when a valid slot of the indexed set holds the request tag. The clock edge that samples the request registers `hit`=1 and `way`=the matching slot.
- R4: A hit leaves every stored tag, valid bit and fill pointer unchanged.
- R5: A miss registers `miss`=1. On the same edge, the request tag is written into the victim slot and that slot's valid bit is set. `way` reports the slot that was filled.
- R6: In a set that has never been filled since reset, the first miss fills way 0 and the second fills way 1.
- R7: In a full set, a miss evicts the slot that was filled earliest, whatever hits occurred in between. The fill pointer toggles on every allocation.
- R8: With `req_valid` low, the next edge registers `hit`=0 and `miss`=0, and the directory does not change.
- R9: Each request yields exactly one of `hit` or `miss`. Allocation touches only the indexed set.
- R10: Slot s*2+w (set s, way w) shows its tag on `dbg_tags[(s*2+w)*4 +: 4]` and its valid bit on `dbg_valid[s*2+w]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | 8 | Byte address of the lookup |
| hit | output | 1 | Registered: previous request hit |
| miss | output | 1 | Registered: previous request missed and allocated |
| way | output | 1 | Registered: slot that hit or was filled |
| dbg_tags | output | 32 | Stored tag of all 8 slots, 4 bits each |
| dbg_valid | output | 8 | Valid bit of all 8 slots |

## Verification
The rising edge that samples a request both updates the directory and registers `hit`, `miss` and `way`. All results of request N are therefore visible right after edge N and stay stable until edge N+1. The driver changes inputs on falling edges and queues the expected outcome, computed from a reference model of the sets. The monitor captures `req_valid` at each rising edge. One nanosecond later it pops the queued item and compares the outcome and the full directory, or, for an idle cycle, confirms that both flags are low and that nothing moved.

// File: rtl/cdir_pkg.sv
`timescale 1ns/1ps
package cdir_pkg;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 2;
  localparam int SET_W  = 2;
  localparam int WAYS   = 2;
  localparam int SETS   = 1 << SET_W;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SLOTS  = SETS * WAYS;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [SET_W-1:0] set_t;
  typedef logic [WAY_W-1:0] way_t;

  function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic set_t set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic way_t next_way(input way_t w);
    return (w == way_t'(WAYS - 1)) ? '0 : way_t'(w + 1'b1);
  endfunction
endpackage

// File: rtl/cdir_set.sv
`timescale 1ns/1ps
module cdir_set
  import cdir_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_en,
  input  way_t                       alloc_way,
  input  tag_t                       alloc_tag,
  output logic [WAYS-1:0][TAG_W-1:0] tags,
  output logic [WAYS-1:0]            valid,
  output way_t                       fifo_ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tags     <= '0;
      valid    <= '0;
      fifo_ptr <= '0;
    end else if (alloc_en) begin
      tags[alloc_way]  <= alloc_tag;
      valid[alloc_way] <= 1'b1;
      fifo_ptr         <= next_way(fifo_ptr);
    end
  end

  AST_IDLE_SET_STABLE: assert property (@(posedge clk) disable iff (rst)
    !alloc_en |=> ($stable(tags) && $stable(valid) && $stable(fifo_ptr))); // R4

  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> (valid[$past(alloc_way)] && tags[$past(alloc_way)] == $past(alloc_tag))); // R5

  AST_PTR_MOVES_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> (fifo_ptr != $past(fifo_ptr))); // R7
endmodule

// File: rtl/cdir_lookup.sv
`timescale 1ns/1ps
module cdir_lookup
  import cdir_pkg::*;
(
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  way_t                       set_ptr,
  input  tag_t                       req_tag,
  output logic                       match,
  output way_t                       match_way,
  output way_t                       victim_way
);
  logic found_free;
  way_t free_way;

  always_comb begin
    match      = 1'b0;
    match_way  = '0;
    found_free = 1'b0;
    free_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_valid[w] && (set_tags[w] == req_tag) && !match) begin
        match     = 1'b1;
        match_way = way_t'(w);
      end
      if (!set_valid[w] && !found_free) begin
        found_free = 1'b1;
        free_way   = way_t'(w);
      end
    end
    victim_way = found_free ? free_way : set_ptr;
  end
endmodule

// File: rtl/cache_tag_dir.sv
`timescale 1ns/1ps
module cache_tag_dir
  import cdir_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   hit,
  output logic                   miss,
  output logic [WAY_W-1:0]       way,
  output logic [SLOTS*TAG_W-1:0] dbg_tags,
  output logic [SLOTS-1:0]       dbg_valid
);
  tag_t req_tag;
  set_t req_set;
  assign req_tag = tag_of(req_addr);
  assign req_set = set_of(req_addr);

  logic [WAYS-1:0][TAG_W-1:0] set_tags_a  [SETS];
  logic [WAYS-1:0]            set_valid_a [SETS];
  way_t                       set_ptr_a   [SETS];
  logic [SETS-1:0]            alloc_sel;

  logic lk_match;
  way_t lk_match_way;
  way_t lk_victim;
  logic hit_fire;
  logic alloc_fire;

  assign hit_fire   = req_valid && lk_match;
  assign alloc_fire = req_valid && !lk_match;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign alloc_sel[s] = alloc_fire && (req_set == set_t'(s));
    cdir_set u_set (
      .clk       (clk),
      .rst       (rst),
      .alloc_en  (alloc_sel[s]),
      .alloc_way (lk_victim),
      .alloc_tag (req_tag),
      .tags      (set_tags_a[s]),
      .valid     (set_valid_a[s]),
      .fifo_ptr  (set_ptr_a[s])
    );
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign dbg_tags[(s*WAYS+w)*TAG_W +: TAG_W] = set_tags_a[s][w];
      assign dbg_valid[s*WAYS+w]                = set_valid_a[s][w];
    end
  end

  cdir_lookup u_lookup (
    .set_tags   (set_tags_a[req_set]),
    .set_valid  (set_valid_a[req_set]),
    .set_ptr    (set_ptr_a[req_set]),
    .req_tag    (req_tag),
    .match      (lk_match),
    .match_way  (lk_match_way),
    .victim_way (lk_victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      miss <= 1'b0;
      way  <= '0;
    end else begin
      hit  <= hit_fire;
      miss <= alloc_fire;
      way  <= lk_match ? lk_match_way : lk_victim;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (hit != miss)); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!hit && !miss)); // R8

  AST_HIT_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
    hit_fire |=> ($stable(dbg_tags) && $stable(dbg_valid))); // R4

  AST_VALID_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~dbg_valid & $past(dbg_valid)) == '0)); // R5

  AST_SINGLE_SET_ALLOC: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_sel)); // R9
endmodule

// File: tb/cache_tag_dir_test.sv
`timescale 1ns/1ps
module cache_tag_dir_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic        hit, miss;
  logic [0:0]  way;
  logic [31:0] dbg_tags;
  logic [7:0]  dbg_valid;

  always #2 clk = ~clk; // 250 MHz

  cache_tag_dir uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit), .miss(miss), .way(way), .dbg_tags(dbg_tags), .dbg_valid(dbg_valid)
  );

  typedef struct {
    logic  e_hit;
    logic  e_miss;
    logic  e_way;
    string label;
  } item_t;

  item_t exp_q[$];
  int    n_total = 0;
  int    n_fail  = 0;
  bit    run     = 1'b0;
  bit    done    = 1'b0;

  logic [3:0] m_tag [4][2];
  logic       m_val [4][2];
  logic       m_ptr [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_tags();
    logic [31:0] v = '0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) v[(s*2+w)*4 +: 4] = m_tag[s][w];
    return v;
  endfunction

  function automatic logic [7:0] model_valid();
    logic [7:0] v = '0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) v[s*2+w] = m_val[s][w];
    return v;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_val[s][w] = 1'b0;
        m_tag[s][w] = '0;
      end
    end
  endtask

  task automatic do_req(input logic [7:0] a, input string label);
    item_t it;
    int    s = int'(a[3:2]);
    logic [3:0] t = a[7:4];
    @(negedge clk);
    it.label = label;
    it.e_hit = 1'b0;
    it.e_miss = 1'b0;
    it.e_way = 1'b0;
    if (m_val[s][0] && m_tag[s][0] == t) begin
      it.e_hit = 1'b1; it.e_way = 1'b0;
    end else if (m_val[s][1] && m_tag[s][1] == t) begin
      it.e_hit = 1'b1; it.e_way = 1'b1;
    end else begin
      it.e_miss = 1'b1;
      if (!m_val[s][0])      it.e_way = 1'b0;
      else if (!m_val[s][1]) it.e_way = 1'b1;
      else                   it.e_way = m_ptr[s];
      m_tag[s][it.e_way] = t;
      m_val[s][it.e_way] = 1'b1;
      m_ptr[s] = ~m_ptr[s];
    end
    exp_q.push_back(it);
    req_valid = 1'b1;
    req_addr  = a;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 8'hA5;
    end
  endtask

  // Monitor: compare at 1 ns after each rising edge
  initial begin
    forever begin
      logic v;
      @(posedge clk);
      v = req_valid;
      #1;
      if (run) begin
        if (v) begin
          item_t it;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected result", 32'(hit), 32'(0));
          end else begin
            it = exp_q.pop_front();
            check(hit  == it.e_hit,  it.label, "hit",  32'(hit),  32'(it.e_hit));
            check(miss == it.e_miss, it.label, "miss", 32'(miss), 32'(it.e_miss));
            check(way  == it.e_way,  it.label, "way",  32'(way),  32'(it.e_way));
          end
          check(dbg_tags == model_tags(), "R10", "tags", dbg_tags, model_tags());
          check(dbg_valid == model_valid(), "R10", "valid", 32'(dbg_valid), 32'(model_valid()));
        end else begin
          check(!hit && !miss, "R8", "idle flags", {30'd0, hit, miss}, 32'd0);
          check(dbg_tags == model_tags(), "R8", "idle tags", dbg_tags, model_tags());
          check(dbg_valid == model_valid(), "R8", "idle valid", 32'(dbg_valid), 32'(model_valid()));
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'h5B;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dbg_valid == 8'h00, "R1", "valid after reset", 32'(dbg_valid), 32'd0);
    check(!hit && !miss, "R1", "flags after reset", {30'd0, hit, miss}, 32'd0);
    rst = 1'b0;
    run = 1'b1;

    do_req(8'h34, "R6");  // set1 tag3 -> way0
    do_req(8'h37, "R2");  // same line, other offset -> hit way0
    do_req(8'h74, "R6");  // set1 tag7 -> way1
    do_req(8'h35, "R3");  // hit way0
    do_req(8'h76, "R4");  // hit way1, no change
    do_req(8'hB4, "R7");  // full: evict way0 (earliest)
    do_req(8'h36, "R7");  // tag3 gone: evict way1 (tag7)
    do_req(8'hB5, "R3");  // hit way0
    do_req(8'h78, "R9");  // set2 independent -> way0
    idle(2);
    do_req(8'h44, "R7");  // set1 full, ptr at way0 -> way0 (tag B evicted)
    do_req(8'h38, "R3");  // tag3 still in set1 way1 and set2 untouched? set2 tag3 miss
    do_req(8'h0C, "R6");  // set3 first fill way0
    idle(1);
    do_req(8'h7B, "R3");  // set2 tag7 hit way0

    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0] && lfsr[5]) idle(1);
      else do_req({2'b00, lfsr[7:6], lfsr[3:0]}, "R9");
    end
    idle(3);

    // R1: reset again returns pointers to way 0
    @(negedge clk);
    rst = 1'b1;
    run = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    check(dbg_valid == 8'h00, "R1", "valid after second reset", 32'(dbg_valid), 32'd0);
    rst = 1'b0;
    run = 1'b1;
    do_req(8'hE4, "R1");  // set1 fill way0 after reset
    do_req(8'hD4, "R6");  // way1
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule